// File: doc/BRIEF.md
# Predictive Dead-Time Delay Controller

This block turns one PWM input into two complementary gate enables, one for the high-side switch and one for the synchronous rectifier. Between the two conduction phases it inserts a dead time whose length is a programmable number of clock ticks. Each switching edge has its own delay code. The code for the high-to-low edge sets the gap between high-side turn-off and low-side turn-on. The code for the low-to-high edge sets the gap between low-side turn-off and high-side turn-on.

The codes are tuned from one cycle to the next rather than from a live sense of the transition in progress. A fixed number of ticks after each PWM edge, the block samples that edge's "rectifier body diode was conducting" flag. If the flag is set, the dead time was too long, so the code drops by one tap. If it is clear, the code rises by one tap. In steady state the codes therefore hunt back and forth around the shortest safe dead time, staying inside a two-tap band. Each tap stands for roughly 4 ns of delay line and is modelled here as one clock tick.

Top module: `pdt_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both gate enables are low and both delay codes read their maximum, 15 with the default 4-bit code.
- R2: The high-side and low-side enables are never high in the same clock cycle.
- R3: When the sampled PWM goes low while the high-side enable is on, the high-side enable drops at that clock edge. The low-side enable then rises exactly code_fall+1 cycles later, where code_fall is the value it held when the high-side enable fell.
- R4: When the sampled PWM goes high while the low-side enable is on, the low-side enable drops at that edge. The high-side enable then rises exactly code_rise+1 cycles later.
- R5: SAMPLE_TICKS clock edges after a falling-edge start, flag_fall is sampled. A 1 (conduction) lowers code_fall by one, and a 0 raises it by one.
- R6: SAMPLE_TICKS clock edges after a rising-edge start, flag_rise is sampled with the same rule applied to code_rise.
- R7: Codes saturate: a step down from 0 leaves 0, a step up from the maximum leaves the maximum, and neither ever wraps.
- R8: A flag has no effect at any edge other than its sample edge, so each code changes at most once per PWM period.
- R9: If the PWM reverses during a dead time, the block switches to the opposite dead-time phase, loaded with that edge's code, and the gate of the aborted phase never turns on.
- R10: With conduction reported whenever a code is above a threshold TH, each code settles into dithering between TH and TH+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; one tick is one delay tap |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | PWM command, synchronous to clk |
| flag_fall | input | 1 | Conduction seen at the high-to-low edge |
| flag_rise | input | 1 | Conduction seen at the low-to-high edge |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side (rectifier) gate enable |
| code_fall | output | CODE_W | Delay code for high-side-off to low-side-on |
| code_rise | output | CODE_W | Delay code for low-side-off to high-side-on |

## Verification
The bench uses the defaults CODE_W = 4 and SAMPLE_TICKS = 20. With 16 taps, a walk from the top code to the floor takes only a handful of 60-cycle PWM periods, so both saturation limits and the converged dither band at TH = 6 are all reached in a short run. Because SAMPLE_TICKS is larger than the longest dead time (16 ticks), every sample falls inside a half-period of 30 ticks. Each measured gap can then be compared against a code that is known not to change while that gap is running, and the bench can hold a flag high in one half of the period and low in the other to prove that only the sample edge matters.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  typedef enum logic [1:0] {
    PH_HS  = 2'd0,
    PH_DTF = 2'd1,
    PH_LS  = 2'd2,
    PH_DTR = 2'd3
  } phase_e;

  // One saturating tap step: shrink when conduction was seen, else grow.
  function automatic logic [7:0] tap_step(input logic [7:0] cur,
                                          input logic [7:0] top,
                                          input logic       shrink);
    logic [7:0] nxt;
    if (shrink) nxt = (cur == 8'd0) ? 8'd0 : cur - 8'd1;
    else        nxt = (cur >= top)  ? top  : cur + 8'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/pdt_phase_fsm.sv
module pdt_phase_fsm
  import pdt_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic [CODE_W-1:0] code_fall,
  input  logic [CODE_W-1:0] code_rise,
  output logic              hs_en,
  output logic              ls_en,
  output logic              fall_start,
  output logic              rise_start
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  phase_e            phase_q;
  logic [CODE_W-1:0] gap_q;

  assign fall_start = !pwm_in && (phase_q == PH_HS || phase_q == PH_DTR);
  assign rise_start =  pwm_in && (phase_q == PH_LS || phase_q == PH_DTF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_DTF;
      gap_q   <= CODE_MAX;
    end else begin
      case (phase_q)
        PH_HS: begin
          if (!pwm_in) begin
            phase_q <= PH_DTF;
            gap_q   <= code_fall;
          end
        end
        PH_DTF: begin
          if (pwm_in) begin
            phase_q <= PH_DTR;
            gap_q   <= code_rise;
          end else if (gap_q == '0) begin
            phase_q <= PH_LS;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        PH_LS: begin
          if (pwm_in) begin
            phase_q <= PH_DTR;
            gap_q   <= code_rise;
          end
        end
        default: begin
          if (!pwm_in) begin
            phase_q <= PH_DTF;
            gap_q   <= code_fall;
          end else if (gap_q == '0) begin
            phase_q <= PH_HS;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
      endcase
    end
  end

  assign hs_en = (phase_q == PH_HS);
  assign ls_en = (phase_q == PH_LS);

endmodule

// File: rtl/pdt_edge_tuner.sv
module pdt_edge_tuner
  import pdt_pkg::*;
#(
  parameter int CODE_W       = 4,
  parameter int SAMPLE_TICKS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              flag,
  output logic [CODE_W-1:0] code,
  output logic              upd
);

  localparam int                 SMP_W    = $clog2(SAMPLE_TICKS + 1);
  localparam logic [SMP_W-1:0]   SMP_LOAD = SMP_W'(SAMPLE_TICKS - 1);
  localparam logic [CODE_W-1:0]  CODE_MAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q;
  logic [SMP_W-1:0]  wait_q;
  logic              armed_q;

  assign upd = armed_q && (wait_q == '0) && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= CODE_MAX;
      wait_q  <= '0;
      armed_q <= 1'b0;
    end else if (start) begin
      armed_q <= 1'b1;
      wait_q  <= SMP_LOAD;
    end else if (upd) begin
      code_q  <= CODE_W'(tap_step(8'(code_q), 8'(CODE_MAX), flag));
      armed_q <= 1'b0;
    end else if (armed_q) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign code = code_q;

endmodule

// File: rtl/pdt_ctrl.sv
module pdt_ctrl
  import pdt_pkg::*;
#(
  parameter int CODE_W       = 4,
  parameter int SAMPLE_TICKS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic              flag_fall,
  input  logic              flag_rise,
  output logic              hs_en,
  output logic              ls_en,
  output logic [CODE_W-1:0] code_fall,
  output logic [CODE_W-1:0] code_rise
);

  localparam int N_EDGE = 2;

  logic [N_EDGE-1:0] start_v;
  logic [N_EDGE-1:0] flag_v;
  logic [N_EDGE-1:0] upd_v;
  logic [CODE_W-1:0] code_v [N_EDGE];

  // Named internal events for the checker.
  logic fall_start, rise_start, fall_upd, rise_upd;

  pdt_phase_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_in     (pwm_in),
    .code_fall  (code_v[0]),
    .code_rise  (code_v[1]),
    .hs_en      (hs_en),
    .ls_en      (ls_en),
    .fall_start (fall_start),
    .rise_start (rise_start)
  );

  assign start_v = {rise_start, fall_start};
  assign flag_v  = {flag_rise, flag_fall};

  for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
    pdt_edge_tuner #(
      .CODE_W       (CODE_W),
      .SAMPLE_TICKS (SAMPLE_TICKS)
    ) u_tune (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_v[e]),
      .flag  (flag_v[e]),
      .code  (code_v[e]),
      .upd   (upd_v[e])
    );
  end

  assign fall_upd  = upd_v[0];
  assign rise_upd  = upd_v[1];
  assign code_fall = code_v[0];
  assign code_rise = code_v[1];

endmodule

// File: rtl/pdt_ctrl_chk.sv
module pdt_ctrl_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hs_en,
  input logic              ls_en,
  input logic              flag_fall,
  input logic              flag_rise,
  input logic              fall_upd,
  input logic              rise_upd,
  input logic [CODE_W-1:0] code_fall,
  input logic [CODE_W-1:0] code_rise
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  a_r3_hs_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |=> !ls_en);

  a_r4_ls_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ls_en |=> !hs_en);

  a_r5_fall_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_upd && flag_fall && code_fall != '0) |=> code_fall == $past(code_fall) - 1'b1);

  a_r5_fall_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_upd && !flag_fall && code_fall != CODE_MAX) |=> code_fall == $past(code_fall) + 1'b1);

  a_r6_rise_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_upd && flag_rise && code_rise != '0) |=> code_rise == $past(code_rise) - 1'b1);

  a_r6_rise_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_upd && !flag_rise && code_rise != CODE_MAX) |=> code_rise == $past(code_rise) + 1'b1);

  a_r7_fall_top: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_upd && !flag_fall && code_fall == CODE_MAX) |=> code_fall == CODE_MAX);

  a_r7_rise_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_upd && flag_rise && code_rise == '0) |=> code_rise == '0);

  a_r8_fall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_upd |=> $stable(code_fall));

  a_r8_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_upd |=> $stable(code_rise));

endmodule

bind pdt_ctrl pdt_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hs_en     (hs_en),
  .ls_en     (ls_en),
  .flag_fall (flag_fall),
  .flag_rise (flag_rise),
  .fall_upd  (fall_upd),
  .rise_upd  (rise_upd),
  .code_fall (code_fall),
  .code_rise (code_rise)
);

// File: tb/sim_pdt_ctrl.sv
module sim_pdt_ctrl;

  localparam int CODE_W = 4;
  localparam int SMP    = 20;
  localparam int HALF   = 30;
  localparam int TH     = 6;
  localparam int NVEC   = 8;

  // Each entry: {flag_fall, flag_rise, expected code_fall, expected code_rise}.
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'd15, 4'd15},
    {1'b1, 1'b1, 4'd14, 4'd14},
    {1'b1, 1'b0, 4'd13, 4'd15},
    {1'b0, 1'b1, 4'd14, 4'd14},
    {1'b1, 1'b1, 4'd13, 4'd13},
    {1'b1, 1'b1, 4'd12, 4'd12},
    {1'b0, 1'b1, 4'd13, 4'd11},
    {1'b1, 1'b0, 4'd12, 4'd12}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0;
  logic flag_fall = 1'b0;
  logic flag_rise = 1'b0;
  logic hs_en, ls_en;
  logic [CODE_W-1:0] code_fall, code_rise;

  int n_chk = 0;
  int n_bad = 0;
  bit model_on = 1'b0;
  bit mon_on = 1'b0;

  always #2.5 clk = ~clk;

  pdt_ctrl #(.CODE_W(CODE_W), .SAMPLE_TICKS(SMP)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .flag_fall(flag_fall), .flag_rise(flag_rise),
    .hs_en(hs_en), .ls_en(ls_en),
    .code_fall(code_fall), .code_rise(code_rise)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Gap monitor (R2, R3, R4).
  logic prev_hs = 1'b0, prev_ls = 1'b0;
  int fgap = 0, rgap = 0, fexp = 0, rexp = 0;
  bit fact = 1'b0, ract = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (hs_en && ls_en) check("R2 overlap", 1, 0);
      if (fact) begin
        if (ls_en) begin check("R3 fall gap", fgap, fexp + 1); fact = 1'b0; end
        else if (hs_en) fact = 1'b0;
        else fgap++;
      end
      if (ract) begin
        if (hs_en) begin check("R4 rise gap", rgap, rexp + 1); ract = 1'b0; end
        else if (ls_en) ract = 1'b0;
        else rgap++;
      end
      if (prev_hs && !hs_en) begin fact = 1'b1; fgap = 1; fexp = int'(code_fall); end
      if (prev_ls && !ls_en) begin ract = 1'b1; rgap = 1; rexp = int'(code_rise); end
    end
    prev_hs = hs_en;
    prev_ls = ls_en;
  end

  task automatic one_half(input logic lvl, input int n, input logic ff, input logic fr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pwm_in = lvl;
      if (model_on) begin
        flag_fall = (int'(code_fall) > TH);
        flag_rise = (int'(code_rise) > TH);
      end else begin
        flag_fall = ff;
        flag_rise = fr;
      end
    end
  endtask

  task automatic period(input logic ff_hi, input logic fr_hi,
                        input logic ff_lo, input logic fr_lo);
    one_half(1'b1, HALF, ff_hi, fr_hi);
    one_half(1'b0, HALF, ff_lo, fr_lo);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 1, 0);
    summary();
  end

  initial begin
    int lo, hi;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    check("R1 hs_en in reset", int'(hs_en), 0);
    check("R1 ls_en in reset", int'(ls_en), 0);
    check("R1 code_fall in reset", int'(code_fall), 15);
    check("R1 code_rise in reset", int'(code_rise), 15);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code_fall after reset", int'(code_fall), 15);
    check("R1 hs_en after reset", int'(hs_en), 0);
    repeat (20) @(negedge clk);
    check("R1 ls_en settles on", int'(ls_en), 1);
    mon_on = 1'b1;

    // Table walk: R5, R6, R7 (top saturation in vector 0)
    for (int v = 0; v < NVEC; v++) begin
      period(VEC[v][9], VEC[v][8], VEC[v][9], VEC[v][8]);
      check("R5 table code_fall", int'(code_fall), int'(VEC[v][7:4]));
      check("R6 table code_rise", int'(code_rise), int'(VEC[v][3:0]));
    end

    // R7: drive to the floor and hold there
    for (int p = 0; p < 14; p++) period(1'b1, 1'b1, 1'b1, 1'b1);
    check("R7 code_fall floor", int'(code_fall), 0);
    check("R7 code_rise floor", int'(code_rise), 0);

    // R8: flags set only away from their sample edges
    period(1'b1, 1'b0, 1'b0, 1'b1);
    check("R8 code_fall off-sample", int'(code_fall), 1);
    check("R8 code_rise off-sample", int'(code_rise), 1);

    // R10: threshold conduction model
    model_on = 1'b1;
    lo = 99; hi = -1;
    for (int p = 0; p < 30; p++) begin
      period(1'b0, 1'b0, 1'b0, 1'b0);
      if (p >= 20) begin
        if (int'(code_fall) < lo) lo = int'(code_fall);
        if (int'(code_fall) > hi) hi = int'(code_fall);
        if (int'(code_rise) < lo) lo = int'(code_rise);
        if (int'(code_rise) > hi) hi = int'(code_rise);
      end
    end
    check("R10 dither low", lo, TH);
    check("R10 dither high", hi, TH + 1);
    model_on = 1'b0;

    // R9: reversal during rising dead time; ls_en is on now
    check("R9 start in ls phase", int'(ls_en), 1);
    mon_on = 1'b0;
    @(negedge clk); pwm_in = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R9 hs stays off", int'(hs_en), 0);
    end
    pwm_in = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hs_en) check("R9 hs stays off", int'(hs_en), 0);
    end
    check("R9 ls back on", int'(ls_en), 1);
    check("R9 hs off", int'(hs_en), 0);

    summary();
  end

endmodule